// File: doc/BRIEF.md
# Multi-Lane Serial Word Deserializer

This block takes the serial readout of one front-end chip and turns it back into parallel words. The chip streams its data over one, two or four data lanes, and a run-time setting picks how many lanes are active. On every clock the block shifts in one bit from each active lane. It gathers them into 24-bit words and tags each finished word with a 4-bit chip identifier. The identifier comes from a per-instance input, so a later combining stage can tell the sources apart once several of these blocks feed one stream.

The incoming stream mixes sync words with data words. At start-up the block does not know where a word begins. It searches for a fixed 24-bit sync pattern, set by a parameter, and checks it at every group position. Once the pattern appears, the word boundary is locked. From then on a finished word leaves the block every 24/L clocks, where L is the active lane count. Each word carries a one-cycle valid strobe. Any word that equals the sync pattern is also flagged, so that a later stage can drop it. A reset or a change of lane count throws away the partial word and the lock.

Top module: `mlane_word_deser`

## Requirements
- R1: While reset is asserted, and directly after it, `word_out` is all zeros and both `word_valid` and `word_sync` are low.
- R2: `lane_mode` 2'b00 selects one lane, 2'b01 selects two lanes and 2'b1x selects four lanes. With L lanes, every clock adds L bits to the word, and lane 0 carries the most significant bit of that group. Over one word, the first clock supplies the top L payload bits.
- R3: Lanes above the active lane count have no effect on any output.
- R4: The output word holds the chip identifier in bits [27:24] and the 24-bit payload in bits [23:0]. The identifier is the value of `chip_id` in the clock that completes the word.
- R5: Before lock, no word is output. Lock is taken when the last 24 bits received equal `SYNC_WORD`. That sync word is itself output, with `word_sync` high.
- R6: Once locked, a word is output exactly every 24/L clocks, and `word_valid` is high for one clock per word.
- R7: `word_sync` is high with `word_valid` exactly when the output payload equals `SYNC_WORD`. Data words leave with `word_sync` low.
- R8: A change of `lane_mode` clears the partial word and drops the lock. No word is output until the sync pattern is found again under the new lane count.
- R9: A reset applied during a locked stream drops the lock. Data that follows without a new sync word produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, one lane group per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_mode | input | 2 | Active lane count: 00 one, 01 two, 1x four |
| lane_in | input | 4 | Serial data lanes, lane 0 most significant in each group |
| chip_id | input | 4 | Identifier appended to every output word |
| word_out | output | 28 | Tagged word: identifier [27:24], payload [23:0] |
| word_valid | output | 1 | One-cycle strobe marking a finished word |
| word_sync | output | 1 | High with `word_valid` when the payload is the sync pattern |

## Verification
The assertions assume that the data lanes continue the chip's stream, and that a new lane count is held steady for a whole word after it changes. The gap check depends on this. They also assume that `chip_id` stays constant across each word. The bench changes the identifier and the lane count only between words, and it fills each unlocked gap with idle zero groups, so that no false sync match can form. Data words are picked so that none of them equals the sync pattern, and no window that straddles neighbouring words rebuilds the pattern. Noise is driven on the unused lanes during the one-lane and two-lane phases.

// File: rtl/mlane_deser_pkg.sv
package mlane_deser_pkg;

  localparam int MAX_LANES = 4;

  typedef enum logic [1:0] {
    LM_ONE   = 2'b00,
    LM_TWO   = 2'b01,
    LM_FOUR  = 2'b10,
    LM_FOURX = 2'b11
  } lane_mode_e;

  typedef enum logic {
    ST_SEEK = 1'b0,
    ST_LOCK = 1'b1
  } align_state_e;

endpackage

// File: rtl/mlane_shift.sv
module mlane_shift
  import mlane_deser_pkg::*;
#(
  parameter int PAYLOAD_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [1:0]           lane_mode,
  input  logic [MAX_LANES-1:0] lane_in,
  output logic [PAYLOAD_W-1:0] sr_next
);

  logic [PAYLOAD_W-1:0] sr_q;
  logic [PAYLOAD_W-1:0] shifted;

  // lane 0 lands in the most significant position of each group
  always_comb begin
    unique case (lane_mode)
      LM_ONE:  shifted = {sr_q[PAYLOAD_W-2:0], lane_in[0]};
      LM_TWO:  shifted = {sr_q[PAYLOAD_W-3:0], lane_in[0], lane_in[1]};
      default: shifted = {sr_q[PAYLOAD_W-5:0], lane_in[0], lane_in[1],
                          lane_in[2], lane_in[3]};
    endcase
    sr_next = clr ? '0 : shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_next;
  end

endmodule

// File: rtl/mlane_align.sv
module mlane_align
  import mlane_deser_pkg::*;
#(
  parameter int                   PAYLOAD_W = 24,
  parameter logic [PAYLOAD_W-1:0] SYNC_WORD = 24'hB4E1D2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [1:0]           lane_mode,
  input  logic [PAYLOAD_W-1:0] sr_next,
  output logic                 word_done,
  output logic                 word_is_sync
);

  localparam int CNT_W = $clog2(PAYLOAD_W);

  align_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_beat;
  logic             match;

  always_comb begin
    unique case (lane_mode)
      LM_ONE:  last_beat = CNT_W'(PAYLOAD_W - 1);
      LM_TWO:  last_beat = CNT_W'(PAYLOAD_W / 2 - 1);
      default: last_beat = CNT_W'(PAYLOAD_W / 4 - 1);
    endcase
  end

  assign match = (sr_next == SYNC_WORD);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    word_done = 1'b0;
    if (clr) begin
      state_d = ST_SEEK;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_SEEK: begin
          if (match) begin
            state_d   = ST_LOCK;
            cnt_d     = '0;
            word_done = 1'b1;
          end
        end
        default: begin
          if (cnt_q == last_beat) begin
            cnt_d     = '0;
            word_done = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign word_is_sync = word_done && match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEEK;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/mlane_word_deser.sv
module mlane_word_deser
  import mlane_deser_pkg::*;
#(
  parameter int                   PAYLOAD_W = 24,
  parameter int                   ID_W      = 4,
  parameter logic [PAYLOAD_W-1:0] SYNC_WORD = 24'hB4E1D2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                lane_mode,
  input  logic [MAX_LANES-1:0]      lane_in,
  input  logic [ID_W-1:0]           chip_id,
  output logic [ID_W+PAYLOAD_W-1:0] word_out,
  output logic                      word_valid,
  output logic                      word_sync
);

  localparam int OUT_W = ID_W + PAYLOAD_W;

  logic [1:0]           mode_q;
  logic                 clr;
  logic [PAYLOAD_W-1:0] sr_next;
  logic                 word_done;
  logic                 word_is_sync;
  logic                 ld_en;
  logic [OUT_W-1:0]     word_d;

  assign clr    = (lane_mode != mode_q);
  assign ld_en  = word_done;
  assign word_d = {chip_id, sr_next};

  mlane_shift #(.PAYLOAD_W(PAYLOAD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .lane_mode (lane_mode),
    .lane_in   (lane_in),
    .sr_next   (sr_next)
  );

  mlane_align #(.PAYLOAD_W(PAYLOAD_W), .SYNC_WORD(SYNC_WORD)) u_align (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .lane_mode    (lane_mode),
    .sr_next      (sr_next),
    .word_done    (word_done),
    .word_is_sync (word_is_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= LM_ONE;
      word_out   <= '0;
      word_valid <= 1'b0;
      word_sync  <= 1'b0;
    end else begin
      mode_q     <= lane_mode;
      word_valid <= word_done;
      word_sync  <= word_is_sync;
      if (ld_en) word_out <= word_d;
    end
  end

endmodule

// File: rtl/mlane_word_deser_chk.sv
module mlane_word_deser_chk #(
  parameter int                   PAYLOAD_W = 24,
  parameter int                   ID_W      = 4,
  parameter logic [PAYLOAD_W-1:0] SYNC_WORD = 24'hB4E1D2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                lane_mode,
  input logic [ID_W-1:0]           chip_id,
  input logic [ID_W+PAYLOAD_W-1:0] word_out,
  input logic                      word_valid,
  input logic                      word_sync
);

  localparam int GAP_W = $clog2(PAYLOAD_W) + 1;

  logic [1:0]       mode_prev;
  logic             seen;
  logic [GAP_W-1:0] gap;
  logic [GAP_W-1:0] want_gap;
  logic             chg;

  assign chg = (lane_mode != mode_prev);

  always_comb begin
    unique case (mode_prev)
      2'b00:   want_gap = GAP_W'(PAYLOAD_W - 1);
      2'b01:   want_gap = GAP_W'(PAYLOAD_W / 2 - 1);
      default: want_gap = GAP_W'(PAYLOAD_W / 4 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_prev <= 2'b00;
      seen      <= 1'b0;
      gap       <= '0;
    end else begin
      mode_prev <= lane_mode;
      if (chg)             seen <= 1'b0;
      else if (word_valid) seen <= 1'b1;
      if (word_valid)      gap  <= '0;
      else if (gap != '1)  gap  <= gap + 1'b1;
    end
  end

  assert_id_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_out[ID_W+PAYLOAD_W-1:PAYLOAD_W] == $past(chip_id));

  assert_sync_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_sync |-> (word_valid && word_out[PAYLOAD_W-1:0] == SYNC_WORD));

  assert_data_unflagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_out[PAYLOAD_W-1:0] != SYNC_WORD) |-> !word_sync);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_word_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && seen) |-> (gap == want_gap));

  assert_first_is_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !seen) |-> word_sync);

  assert_mode_change_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !word_valid);

endmodule

bind mlane_word_deser mlane_word_deser_chk #(
  .PAYLOAD_W (PAYLOAD_W),
  .ID_W      (ID_W),
  .SYNC_WORD (SYNC_WORD)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lane_mode  (lane_mode),
  .chip_id    (chip_id),
  .word_out   (word_out),
  .word_valid (word_valid),
  .word_sync  (word_sync)
);

// File: tb/mlane_word_deser_bench.sv
`timescale 1ns/1ps
module mlane_word_deser_bench;

  localparam int          PW   = 24;
  localparam logic [23:0] SYNC = 24'hB4E1D2;

  logic        clk;
  logic        rst_n;
  logic [1:0]  lane_mode;
  logic [3:0]  lane_in;
  logic [3:0]  chip_id;
  logic [27:0] word_out;
  logic        word_valid;
  logic        word_sync;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int cur_lanes = 1;
  bit finished = 0;

  logic [28:0] exp_q[$];
  string       tag_q[$];

  mlane_word_deser #(.PAYLOAD_W(24), .ID_W(4), .SYNC_WORD(SYNC)) u_mlane_word_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_mode  (lane_mode),
    .lane_in    (lane_in),
    .chip_id    (chip_id),
    .word_out   (word_out),
    .word_valid (word_valid),
    .word_sync  (word_sync)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on every strobe
  logic prev_valid = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst_n && word_valid) begin
      vcount++;
      check(!prev_valid, "R6 pulse", 32'(prev_valid), 32'd0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected word", 32'(word_out), 32'hFFFFFFFF);
      end else begin
        logic [28:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({word_sync, word_out} == e, t, 32'({word_sync, word_out}), 32'(e));
      end
    end
    prev_valid = rst_n && word_valid;
  end

  task automatic drive_group(input logic [23:0] w, input int c);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      if (i < cur_lanes) lane_in[i] = w[PW - 1 - c * cur_lanes - i];
      else               lane_in[i] = 1'($urandom);
    end
  endtask

  task automatic send_word(input logic [23:0] w, input bit expect_out, input string tag);
    if (expect_out) begin
      exp_q.push_back({(w == SYNC), chip_id, w});
      tag_q.push_back(tag);
    end
    for (int c = 0; c < PW / cur_lanes; c++) drive_group(w, c);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive_group(24'h0, 0);
  endtask

  task automatic set_mode(input logic [1:0] m, input logic [3:0] id);
    @(negedge clk);
    lane_mode = m;
    chip_id   = id;
    cur_lanes = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
    idle(3);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v0;
    rst_n     = 1'b0;
    lane_mode = 2'b00;
    lane_in   = 4'h0;
    chip_id   = 4'h3;
    repeat (3) @(negedge clk);
    check(word_out == 28'h0, "R1 word_out", 32'(word_out), 32'h0);
    check(!word_valid, "R1 valid", 32'(word_valid), 32'h0);
    check(!word_sync, "R1 sync", 32'(word_sync), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!word_valid && word_out == 28'h0, "R1 after release", 32'(word_out), 32'h0);

    // one lane, unused lanes toggling
    idle(6);
    v0 = vcount;
    send_word(24'h123456, 0, "R5");
    send_word(24'h0F0F0F, 0, "R5");
    idle(2);
    check(vcount == v0, "R5 no output before lock", 32'(vcount - v0), 32'd0);
    send_word(SYNC,        1, "R5 lock");
    send_word(24'h5A3C96,  1, "R2 R3 R4 one lane");
    send_word(24'hFFFFFF,  1, "R2 R3 one lane");
    send_word(SYNC,        1, "R7 mid-stream sync");
    send_word(24'h000000,  1, "R6 R7 zero word");
    send_word(24'h800001,  1, "R2 bit order");

    // two lanes, new identifier
    set_mode(2'b01, 4'h9);
    v0 = vcount;
    send_word(24'h3C3C3C, 0, "R8");
    send_word(24'h765432, 0, "R8");
    idle(2);
    check(vcount == v0, "R8 lock dropped on mode change", 32'(vcount - v0), 32'd0);
    send_word(SYNC,       1, "R8 relock");
    send_word(24'hA1B2C3, 1, "R2 R3 two lanes");
    send_word(24'h0000FF, 1, "R4 R6 two lanes");
    send_word(24'hC00003, 1, "R2 bit order two lanes");

    // four lanes
    set_mode(2'b10, 4'hF);
    send_word(SYNC,       1, "R5 four lanes");
    send_word(24'h13579B, 1, "R2 four lanes");
    send_word(24'hFEDCBA, 1, "R4 R6 four lanes");
    send_word(SYNC,       1, "R7 four lanes");
    send_word(24'h00A000, 1, "R2 four lanes");

    // reset during a locked stream
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!word_valid && !word_sync && word_out == 28'h0, "R9 R1 reset clears",
          32'(word_out), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    v0 = vcount;
    send_word(24'h2468AC, 0, "R9");
    send_word(24'h111111, 0, "R9");
    send_word(24'h2468AC, 0, "R9");
    idle(2);
    check(vcount == v0, "R9 no output after reset", 32'(vcount - v0), 32'd0);
    send_word(SYNC,       1, "R9 relock");
    send_word(24'h9ABCDE, 1, "R9 data after relock");

    // stop the stream by a mode change and drain
    set_mode(2'b00, 4'h3);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R6 all expected words seen", 32'(exp_q.size()), 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule